// File: doc/BRIEF.md
# Fetch-Ahead Bus Unit with Byte Queue

This block is the memory-facing half of a 16-bit processor whose work is split between a fetch side and an execute side. It holds four segment base registers and turns a segment and a 16-bit offset into a 20-bit physical address: the base is moved up by four bit places, the offset is added, and any carry out of bit 19 is dropped. Whenever its byte queue has room and no operand transfer is waiting, it reads code at the code segment plus its own fetch offset. It then offers the fetched bytes one at a time to the execute side over a valid/ready pair.

The execute side can also ask for a 16-bit operand read or write through any of the four segments. Such a request takes the bus ahead of prefetch at the next bus start. A flush command, used when the program changes flow, empties the queue and discards any code read still in flight. It then restarts fetching at a new offset. Memory sits behind a plain request/acknowledge port. A request stays up, with its address and data held, until the acknowledge arrives.

Top module: `biu_top`

## Requirements
- R1: Four segment registers are selected by a 2-bit code: 0 code, 1 data, 2 stack, 3 extra. A write with `seg_we` high loads `seg_wdata` into the selected register at the clock edge. Operand requests use the register selected by `op_seg`.
- R2: The address on `mem_addr` for any request is (segment × 16 + offset) modulo 2^20. For example, segment FFFF with offset 0025 gives 00015.
- R3: Code bytes leave the queue in ascending fetch-offset order, starting at the last flush target. Each byte equals memory at code segment × 16 + offset.
- R4: The queue never holds more than six bytes. If the consumer stalls, fetching stops once no further fetch fits. From an even flush target, exactly six bytes are fetched.
- R5: A two-byte fetch (`mem_word`=1) is issued only at an even offset and only when at least two queue slots are free. At an odd offset a one-byte fetch (`mem_word`=0) is issued. So an odd flush target fills the queue with five bytes, and popping one byte then allows a further two-byte fetch.
- R6: An operand read returns {mem[a+1], mem[a]} on `op_rdata`. An operand write stores `op_wdata` low byte at a and high byte at a+1. Completion is shown by a one-cycle `op_done` pulse.
- R7: While an operand request is pending, at most the one code fetch already in flight reaches the bus before the operand transfer.
- R8: A flush discards every queued byte and the data of any code fetch in flight. The next byte delivered is from the flush target.
- R9: A byte is taken when `q_valid` and `q_ready` are both high at a clock edge, at most one per clock. While `q_valid` is high and `q_ready` low, `q_byte` holds its value.
- R10: During and right after reset, `q_valid`, `mem_req` and `op_done` are low. The code segment and fetch offset start at their reset parameters.
- R11: Once raised, `mem_req` stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_sel | input | 2 | Segment register select (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | SEG_W | Segment write value |
| flush | input | 1 | Empty queue and restart fetch |
| flush_ip | input | SEG_W | New fetch offset on flush |
| q_valid | output | 1 | Queue head byte available |
| q_byte | output | 8 | Queue head byte |
| q_ready | input | 1 | Consumer takes the head byte |
| op_req | input | 1 | Operand request, held until op_done |
| op_we | input | 1 | Operand direction, 1 = write |
| op_seg | input | 2 | Operand segment select |
| op_off | input | SEG_W | Operand offset |
| op_wdata | input | 16 | Operand write word |
| op_done | output | 1 | One-cycle operand completion pulse |
| op_rdata | output | 16 | Operand read word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_word | output | 1 | 1 = two bytes, 0 = one byte |
| mem_addr | output | SEG_W+OFS_SHIFT | Physical byte address |
| mem_wdata | output | 16 | Memory write word |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 16 | Memory read word, byte at the address in bits 7:0 |

## Verification
The bench uses the default build: 16-bit segments, a four-place shift, a six-byte queue, and zero reset values for the code segment and fetch offset. With a six-byte queue, stall tests show the difference between even and odd flush targets: even targets fill all six slots, odd targets stop at five. With the 20-bit address width, a stack segment of FFFF carries past bit 19, so the wrap of the address sum can be observed at the memory port. Memory latency is drawn at random from 0 to 3 cycles. This lets acknowledges land in the same cycle as a flush, during a pending operand request, and while the consumer stalls.

// File: rtl/biu_pkg.sv
package biu_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int NUM_SEGS = 4;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_OPER  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/biu_segfile.sv
module biu_segfile
  import biu_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFS_SHIFT = 4,
  parameter int PA_W      = SEG_W + OFS_SHIFT,
  parameter logic [SEG_W-1:0] RESET_CS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [SEG_W-1:0] wdata,
  input  logic [SEG_W-1:0] fetch_off,
  output logic [PA_W-1:0]  fetch_pa,
  input  logic [1:0]       op_sel,
  input  logic [SEG_W-1:0] op_off,
  output logic [PA_W-1:0]  op_pa
);
  logic [SEG_W-1:0] seg_q [NUM_SEGS];

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    localparam logic [SEG_W-1:0] INIT = (g == int'(SEG_CODE)) ? RESET_CS : '0;
    always_ff @(posedge clk) begin
      if (rst)                        seg_q[g] <= INIT;
      else if (we && sel == 2'(g))    seg_q[g] <= wdata;
    end
  end

  // sum is truncated to PA_W bits: carry out of the top bit is dropped
  function automatic logic [PA_W-1:0] phys(input logic [SEG_W-1:0] s,
                                           input logic [SEG_W-1:0] o);
    logic [PA_W-1:0] base;
    base = {s, {OFS_SHIFT{1'b0}}};
    return base + PA_W'(o);
  endfunction

  always_comb begin
    fetch_pa = phys(seg_q[int'(SEG_CODE)], fetch_off);
    op_pa    = phys(seg_q[op_sel], op_off);
  end
endmodule

// File: rtl/biu_pfq.sv
module biu_pfq
  import biu_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [1:0]        push_n,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop_ready,
  output logic              q_valid,
  output logic [BYTE_W-1:0] q_byte,
  output logic [CNT_W-1:0]  free
);
  logic [BYTE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign q_valid = (cnt_q != '0);
  assign q_byte  = store[rd_q];
  assign free    = CNT_W'(DEPTH) - cnt_q;
  assign pop     = q_valid && pop_ready && !clear;

  // storage without reset, write-only ports
  always_ff @(posedge clk) begin
    if (!clear && push_n != 2'd0) store[wr_q] <= push_data[BYTE_W-1:0];
    if (!clear && push_n == 2'd2) store[nxt(wr_q)] <= push_data[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (push_n)
        2'd1:    wr_q <= nxt(wr_q);
        2'd2:    wr_q <= nxt(nxt(wr_q));
        default: wr_q <= wr_q;
      endcase
      if (pop) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_n) - CNT_W'(pop);
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  a_r4_push_fits: assert property (@(posedge clk) disable iff (rst)
    (push_n != 2'd0 && !clear) |-> (CNT_W'(push_n) <= free));
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> !q_valid);
  a_r9_head_holds: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !pop_ready && !clear) |=> (q_valid && $stable(q_byte)));
endmodule

// File: rtl/biu_bus_seq.sv
module biu_bus_seq
  import biu_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int PA_W  = 20,
  parameter int CNT_W = 3,
  parameter logic [SEG_W-1:0] RESET_IP = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [SEG_W-1:0]  flush_ip,
  input  logic              op_req,
  input  logic              op_we,
  input  logic [WORD_W-1:0] op_wdata,
  output logic              op_done,
  output logic [WORD_W-1:0] op_rdata,
  output logic [SEG_W-1:0]  fetch_off,
  input  logic [PA_W-1:0]   fetch_pa,
  input  logic [PA_W-1:0]   op_pa,
  input  logic [CNT_W-1:0]  free,
  output logic [1:0]        push_n,
  output logic [WORD_W-1:0] push_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_word,
  output logic [PA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  bus_state_e       state_q;
  logic [SEG_W-1:0] ip_q;
  logic             drop_q;
  logic             keep, start_op, start_fetch, fetch_fits;

  assign fetch_off  = ip_q;
  assign keep       = (state_q == BUS_FETCH) && mem_ack && !drop_q && !flush;
  assign push_n     = keep ? (mem_word ? 2'd2 : 2'd1) : 2'd0;
  assign push_data  = mem_rdata;
  assign fetch_fits = ip_q[0] ? (free != '0) : (free >= CNT_W'(2));
  assign start_op   = (state_q == BUS_IDLE) && !flush && op_req && !op_done;
  assign start_fetch = (state_q == BUS_IDLE) && !flush && !start_op && fetch_fits;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BUS_IDLE;
      ip_q      <= RESET_IP;
      drop_q    <= 1'b0;
      op_done   <= 1'b0;
      op_rdata  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_word  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      op_done <= 1'b0;
      if (flush)     ip_q <= flush_ip;
      else if (keep) ip_q <= ip_q + SEG_W'(push_n);

      unique case (state_q)
        BUS_IDLE: begin
          drop_q <= 1'b0;
          if (start_op) begin
            mem_req   <= 1'b1;
            mem_we    <= op_we;
            mem_word  <= 1'b1;
            mem_addr  <= op_pa;
            mem_wdata <= op_wdata;
            state_q   <= BUS_OPER;
          end else if (start_fetch) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_word <= !ip_q[0];
            mem_addr <= fetch_pa;
            state_q  <= BUS_FETCH;
          end
        end
        BUS_FETCH: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            drop_q  <= 1'b0;
            state_q <= BUS_IDLE;
          end else if (flush) begin
            drop_q <= 1'b1;
          end
        end
        BUS_OPER: begin
          if (mem_ack) begin
            mem_req  <= 1'b0;
            op_done  <= 1'b1;
            op_rdata <= mem_rdata;
            state_q  <= BUS_IDLE;
          end
        end
        default: state_q <= BUS_IDLE;
      endcase
    end
  end

  a_r5_word_even: assert property (@(posedge clk) disable iff (rst)
    (mem_req && state_q == BUS_FETCH && mem_word) |-> !mem_addr[0]);
  a_r7_operand_wins: assert property (@(posedge clk) disable iff (rst)
    (state_q == BUS_IDLE && op_req && !op_done && !flush) |=> (mem_req && state_q == BUS_OPER));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_word)));
endmodule

// File: rtl/biu_top.sv
module biu_top
  import biu_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFS_SHIFT = 4,
  parameter int Q_DEPTH   = 6,
  parameter logic [SEG_W-1:0] RESET_CS = '0,
  parameter logic [SEG_W-1:0] RESET_IP = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       seg_we,
  input  logic [1:0]                 seg_sel,
  input  logic [SEG_W-1:0]           seg_wdata,
  input  logic                       flush,
  input  logic [SEG_W-1:0]           flush_ip,
  output logic                       q_valid,
  output logic [7:0]                 q_byte,
  input  logic                       q_ready,
  input  logic                       op_req,
  input  logic                       op_we,
  input  logic [1:0]                 op_seg,
  input  logic [SEG_W-1:0]           op_off,
  input  logic [15:0]                op_wdata,
  output logic                       op_done,
  output logic [15:0]                op_rdata,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic                       mem_word,
  output logic [SEG_W+OFS_SHIFT-1:0] mem_addr,
  output logic [15:0]                mem_wdata,
  input  logic                       mem_ack,
  input  logic [15:0]                mem_rdata
);
  localparam int PA_W  = SEG_W + OFS_SHIFT;
  localparam int CNT_W = $clog2(Q_DEPTH + 1);

  logic [SEG_W-1:0]  fetch_off;
  logic [PA_W-1:0]   fetch_pa, op_pa;
  logic [CNT_W-1:0]  free;
  logic [1:0]        push_n;
  logic [WORD_W-1:0] push_data;

  biu_segfile #(.SEG_W(SEG_W), .OFS_SHIFT(OFS_SHIFT), .PA_W(PA_W), .RESET_CS(RESET_CS)) u_seg (
    .clk(clk), .rst(rst), .we(seg_we), .sel(seg_sel), .wdata(seg_wdata),
    .fetch_off(fetch_off), .fetch_pa(fetch_pa),
    .op_sel(op_seg), .op_off(op_off), .op_pa(op_pa)
  );

  biu_pfq #(.DEPTH(Q_DEPTH), .CNT_W(CNT_W)) u_q (
    .clk(clk), .rst(rst), .clear(flush), .push_n(push_n), .push_data(push_data),
    .pop_ready(q_ready), .q_valid(q_valid), .q_byte(q_byte), .free(free)
  );

  biu_bus_seq #(.SEG_W(SEG_W), .PA_W(PA_W), .CNT_W(CNT_W), .RESET_IP(RESET_IP)) u_seq (
    .clk(clk), .rst(rst), .flush(flush), .flush_ip(flush_ip),
    .op_req(op_req), .op_we(op_we), .op_wdata(op_wdata),
    .op_done(op_done), .op_rdata(op_rdata),
    .fetch_off(fetch_off), .fetch_pa(fetch_pa), .op_pa(op_pa), .free(free),
    .push_n(push_n), .push_data(push_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/tb_biu_top.sv
module tb_biu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_we = 0;
  logic [1:0]  seg_sel = 0;
  logic [15:0] seg_wdata = 0;
  logic        flush = 0;
  logic [15:0] flush_ip = 0;
  logic        q_valid;
  logic [7:0]  q_byte;
  logic        q_ready = 0;
  logic        op_req = 0, op_we = 0;
  logic [1:0]  op_seg = 0;
  logic [15:0] op_off = 0, op_wdata = 0;
  logic        op_done;
  logic [15:0] op_rdata;
  logic        mem_req, mem_we, mem_word;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 0;
  logic [15:0] mem_rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  biu_top dut (
    .clk(clk), .rst(rst), .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
    .flush(flush), .flush_ip(flush_ip), .q_valid(q_valid), .q_byte(q_byte), .q_ready(q_ready),
    .op_req(op_req), .op_we(op_we), .op_seg(op_seg), .op_off(op_off), .op_wdata(op_wdata),
    .op_done(op_done), .op_rdata(op_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic [15:0] segm [4];
  logic [7:0]  wmem [bit [19:0]];
  logic [15:0] exp_ip = 0;
  bit          checking = 0, after_flush = 0;
  // operand tracking
  bit          op_active = 0, op_seen = 0, op_is_wr = 0;
  logic [19:0] op_exp_addr = 0, op_addr_seen = 0;
  int          op_fetch_starts = 0;
  // memory responder state
  bit          busy = 0;
  int          lat = 0;
  int          acked = 0, byte_fetches = 0;
  bit          first_seen = 0, first_word = 0;

  function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [7:0] mb(input logic [19:0] a);
    if (wmem.exists(a)) return wmem[a];
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic bit is_code(input logic [19:0] a);
    logic [19:0] d;
    d = a - {segm[0], 4'h0};
    return d < 20'h10000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random latency 0..3, one-cycle acknowledge
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; busy = 0;
    end else if (mem_ack) begin
      mem_ack = 0; busy = 0;
    end else if (mem_req) begin
      if (!busy) begin
        busy = 1;
        lat = int'($urandom % 4);
        if (is_code(mem_addr)) begin
          if (op_active) op_fetch_starts++;
        end else if (op_active) begin
          op_seen = 1; op_addr_seen = mem_addr;
        end
      end
      if (lat == 0) begin
        mem_ack = 1;
        if (mem_we) begin
          wmem[mem_addr] = mem_wdata[7:0];
          wmem[mem_addr + 20'd1] = mem_wdata[15:8];
        end else begin
          mem_rdata = mem_word ? {mb(mem_addr + 20'd1), mb(mem_addr)} : {8'hEE, mb(mem_addr)};
          if (is_code(mem_addr)) begin
            acked += mem_word ? 2 : 1;
            if (!mem_word) byte_fetches++;
            if (!first_seen) begin first_seen = 1; first_word = mem_word; end
          end
        end
      end else lat--;
    end
  end

  // one clock of stimulus and checking, all at the falling edge
  task automatic tick(input bit rdy, input bit fl, input logic [15:0] tgt);
    logic [19:0] a;
    q_ready = rdy; flush = fl; flush_ip = tgt;
    if (op_active && op_done) begin
      chk(op_seen && op_addr_seen == op_exp_addr, "R2 operand address", {12'h0, op_addr_seen}, {12'h0, op_exp_addr});
      chk(op_fetch_starts <= 1, "R7 fetches before operand", op_fetch_starts, 1);
      if (!op_is_wr) begin
        a = op_exp_addr;
        chk(op_rdata == {mb(a + 20'd1), mb(a)}, "R6 operand read data", {16'h0, op_rdata}, {16'h0, mb(a + 20'd1), mb(a)});
      end
      op_req = 0; op_active = 0;
    end
    if (fl) begin
      exp_ip = tgt; after_flush = 1;
    end else if (checking && q_valid && rdy) begin
      a = pa(segm[0], exp_ip);
      if (after_flush)
        chk(q_byte == mb(a), "R8 first byte after flush", {24'h0, q_byte}, {24'h0, mb(a)});
      else
        chk(q_byte == mb(a), "R3 byte stream order", {24'h0, q_byte}, {24'h0, mb(a)});
      exp_ip++; after_flush = 0;
    end
    @(negedge clk);
  endtask

  task automatic stall(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic seg_write(input logic [1:0] s, input logic [15:0] v);
    seg_we = 1; seg_sel = s; seg_wdata = v;
    tick(0, 0, 0);
    seg_we = 0; segm[s] = v;
  endtask

  task automatic op_launch(input bit we, input logic [1:0] s, input logic [15:0] off, input logic [15:0] wd);
    op_exp_addr = pa(segm[s], off);
    op_req = 1; op_we = we; op_seg = s; op_off = off; op_wdata = wd;
    op_is_wr = we; op_active = 1; op_seen = 0; op_fetch_starts = 0;
  endtask

  task automatic do_op(input bit we, input logic [1:0] s, input logic [15:0] off, input logic [15:0] wd);
    op_launch(we, s, off, wd);
    for (int k = 0; k < 300 && op_active; k++) tick(1, 0, 0);
    if (op_active) begin
      chk(0, "R6 operand completion", 0, 1);
      op_req = 0; op_active = 0;
    end
  endtask

  task automatic restart_counted(input logic [15:0] tgt);
    acked = 0; byte_fetches = 0; first_seen = 0;
    tick(0, 1, tgt);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    logic [15:0] rd;
    rd = 16'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) segm[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(!q_valid && !mem_req && !op_done, "R10 reset outputs", {q_valid, mem_req, op_done}, 0);
    rst = 0;
    @(negedge clk);
    chk(!q_valid && !op_done, "R10 after reset", {q_valid, op_done}, 0);

    // R1: segment setup, code segment change takes effect on flush
    seg_write(2'd0, 16'h1234);
    seg_write(2'd1, 16'h9000);
    seg_write(2'd3, 16'h9000);
    seg_write(2'd2, 16'hFFFF);
    checking = 1;
    tick(0, 1, 16'h0100);

    // R4 / R5: even target fills six bytes with word fetches only
    stall(40);
    restart_counted(16'h0200);
    stall(40);
    chk(acked == 6, "R4 queue fill from even target", acked, 6);
    chk(byte_fetches == 0, "R5 even target uses word fetches", byte_fetches, 0);
    chk(!mem_req, "R4 fetch stops when full", mem_req, 0);
    for (int i = 0; i < 12; i++) tick(1, 0, 0);

    // R5: odd target, single-byte realign, five bytes then wait for two free
    stall(40);
    restart_counted(16'h0301);
    stall(40);
    chk(first_seen && !first_word, "R5 odd target fetches one byte", first_word, 0);
    chk(acked == 5, "R5 odd target fills five bytes", acked, 5);
    chk(!mem_req, "R5 no word fetch with one slot free", mem_req, 0);
    tick(1, 0, 0);
    stall(20);
    chk(acked == 7, "R5 word fetch after one pop", acked, 7);
    for (int i = 0; i < 20; i++) tick(1, 0, 0);

    // R9: head byte held while stalled
    stall(40);
    held = q_byte;
    chk(q_valid && held == mb(pa(segm[0], exp_ip)), "R3 head byte value", {24'h0, held}, {24'h0, mb(pa(segm[0], exp_ip))});
    stall(5);
    chk(q_valid && q_byte == held, "R9 head byte stable when not ready", {24'h0, q_byte}, {24'h0, held});

    // R6 / R1 / R7: operand transfers during streaming
    do_op(1, 2'd1, 16'h0010, 16'hBEEF);
    do_op(0, 2'd3, 16'h0010, 16'h0000);
    chk(op_rdata == 16'hBEEF, "R1 extra segment sees data write", {16'h0, op_rdata}, 32'hBEEF);
    do_op(0, 2'd1, 16'h0011, 16'h0000);
    // R2: stack segment FFFF + 0025 wraps to 00015
    do_op(1, 2'd2, 16'h0025, 16'hA55A);
    chk(op_addr_seen == 20'h00015, "R2 address wraps modulo 2^20", {12'h0, op_addr_seen}, 32'h00015);
    do_op(0, 2'd2, 16'h0025, 16'h0000);
    chk(op_rdata == 16'hA55A, "R6 write then read back", {16'h0, op_rdata}, 32'hA55A);

    // random mix: stalls, flushes (incl. during fetches), operand traffic
    for (int i = 0; i < 3000; i++) begin
      bit fl;
      fl = ($urandom % 100) < 3;
      if (!op_active && !fl && ($urandom % 100) < 2)
        op_launch(1'($urandom % 2), ($urandom % 2) ? 2'd1 : 2'd3,
                  16'($urandom % 256), 16'($urandom));
      tick(($urandom % 10) < 7, fl, 16'($urandom));
    end
    for (int k = 0; k < 300 && op_active; k++) tick(1, 0, 0);
    flush = 0; q_ready = 0;
    finish_run();
  end
endmodule